// File: doc/BRIEF.md
# Double-Data-Rate Burst SRAM Port

This block models the synchronous side of a pipelined double-data-rate SRAM. It has a small internal array. The port runs on a beat clock `clk`. Every rising edge is one beat, and beats alternate between the true phase (K) and the complementary phase (K#) of the input clock pair. The `k_beat` output is high when the next edge is a K edge. Commands are taken only on K edges. A command is the active-low load strobe, a read/write select and an address. Each accepted load starts a four-beat burst. The two low address bits step through the burst and wrap, while the upper bits stay fixed.

Writes are late writes. The data words arrive on the four beats that follow the command edge. They are held in a set of per-beat write slots, and each slot is committed to the array only when the next write burst reaches the same beat position. Reads look up both the slots and the array, so a read always returns the newest data. Read words leave through a fixed pipeline, and each word is marked by `rvalid`. A load that arrives while a burst is still running is dropped, and `ld_err` reports it.

Top module: `ddrsram_port`

## Requirements
- R1: `ld_n`, `rw` and `addr` are sampled only on K edges (the edge after a beat where `k_beat` is high). A load presented on a K# edge starts nothing and raises no error. After reset release, `k_beat` alternates every beat.
- R2: A K edge with `ld_n` high starts no operation, and `rvalid` stays low when no read is in flight.
- R3: A burst touches four addresses. The upper address bits equal those of the command. The low two bits start at the command's low two bits and increment modulo 4 (for example, base low bits 2 give 2, 3, 0, 1).
- R4: `rw` = 1 selects a read and `rw` = 0 selects a write.
- R5: For a write accepted at edge E, the word on `wdata` at edge E+1+k is stored at burst address k (k = 0..3).
- R6: For a read accepted at edge E, `rvalid` is high and `rdata` carries burst word k after edge E+3+k. Back-to-back reads give unbroken runs whose length is a multiple of four.
- R7: A read returns the most recently written data for each address, whether that data is still in the write slots or already committed to the array.
- R8: A load on a K edge while a burst is active and not in its last beat is ignored. `ld_err` is high for exactly the following beat. The dropped command writes nothing and does not disturb the running burst.
- R9: A write may follow a read with no idle beat. A read may follow a write to the same burst with no idle beat and returns the new data.
- R10: `rdata` is all zeros whenever `rvalid` is low.
- R11: While reset is held, `rvalid` = 0, `ld_err` = 0, `rdata` = 0 and `k_beat` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock. Each rising edge is one K or K# beat |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n | input | 1 | Active-low load strobe, sampled on K edges |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW (8) | Burst start address |
| wdata | input | DW (36) | Write data, one word per beat |
| rdata | output | DW (36) | Read data, one word per beat, zero when not valid |
| rvalid | output | 1 | Marks a valid read word on `rdata` |
| k_beat | output | 1 | High when the next edge is a K edge |
| ld_err | output | 1 | Pulses one beat after a load was dropped because a burst was active |

## Verification
Aligned write bursts fill a region and read back, which separates the address step from the data capture. Unaligned start addresses then show whether the low bits wrap inside the four-word group or carry into the upper bits. A read issued directly after a write to the same group, and a read of a group whose data was just pushed from the slots into the array, tell forwarding apart from array access. Loads placed on K# beats and loads placed in the middle of a burst check that stray strobes neither corrupt memory nor disturb the running burst. A random mix of bursts over a small address range, compared against a reference memory, covers the remaining orderings.

// File: rtl/ddrsram_pkg.sv
package ddrsram_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } ddr_op_e;

endpackage

// File: rtl/ddrsram_beat_ctl.sv
// Beat sequencer: phase tracking, command acceptance, burst counter,
// wrap-around beat address and the dropped-load flag.
module ddrsram_beat_ctl
  import ddrsram_pkg::*;
#(
  parameter int AW  = 8,
  parameter int BLB = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_n,
  input  logic           rw,
  input  logic [AW-1:0]  addr,
  output logic           k_beat,
  output logic           beat_act,
  output logic           beat_rd,
  output logic [BLB-1:0] beat_idx,
  output logic [AW-1:0]  beat_addr,
  output logic           drop_err
);

  localparam int             BEATS    = 1 << BLB;
  localparam logic [BLB-1:0] LAST_IDX = BLB'(BEATS - 1);

  logic           ph_q, ph_d;
  logic           act_q, act_d;
  logic [BLB-1:0] cnt_q, cnt_d;
  logic [AW-1:0]  base_q, base_d;
  ddr_op_e        op_q, op_d;
  logic           err_q, err_d;

  logic load, last, take;

  always_comb begin
    ph_d   = ~ph_q;
    load   = ~ld_n & ~ph_q;
    last   = act_q & (cnt_q == LAST_IDX);
    take   = load & (~act_q | last);
    err_d  = load & act_q & ~last;
    act_d  = act_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    op_d   = op_q;
    if (take) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      base_d = addr;
      op_d   = ddr_op_e'(rw);
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      op_q   <= OP_WRITE;
      err_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
      if (take) begin
        base_q <= base_d;
        op_q   <= op_d;
      end
    end
  end

  assign k_beat    = ~ph_q;
  assign beat_act  = act_q;
  assign beat_rd   = (op_q == OP_READ);
  assign beat_idx  = cnt_q;
  assign beat_addr = {base_q[AW-1:BLB], base_q[BLB-1:0] + cnt_q};
  assign drop_err  = err_q;

endmodule

// File: rtl/ddrsram_late_wr.sv
// Late-write slots, one per beat position. A slot is committed to the
// array when the next write burst reaches that position; reads forward
// from any matching slot.
module ddrsram_late_wr #(
  parameter int AW  = 8,
  parameter int DW  = 36,
  parameter int BLB = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_beat,
  input  logic [BLB-1:0] beat_idx,
  input  logic [AW-1:0]  beat_addr,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  arr_rdata,
  output logic [DW-1:0]  lk_data,
  output logic           cm_we,
  output logic [AW-1:0]  cm_addr,
  output logic [DW-1:0]  cm_data
);

  localparam int NS = 1 << BLB;

  logic          sv [NS];
  logic [AW-1:0] sa [NS];
  logic [DW-1:0] sd [NS];

  for (genvar j = 0; j < NS; j++) begin : g_slot
    logic          v_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;
    logic          fill;

    assign fill = wr_beat & (beat_idx == BLB'(j));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    v_q <= 1'b0;
      else if (fill) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (fill) begin
        a_q <= beat_addr;
        d_q <= wdata;
      end
    end

    assign sv[j] = v_q;
    assign sa[j] = a_q;
    assign sd[j] = d_q;
  end

  assign cm_we   = wr_beat & sv[beat_idx];
  assign cm_addr = sa[beat_idx];
  assign cm_data = sd[beat_idx];

  logic          hit;
  logic [DW-1:0] fwd;

  always_comb begin
    hit = 1'b0;
    fwd = '0;
    for (int j = 0; j < NS; j++) begin
      if (sv[j] && (sa[j] == beat_addr)) begin
        hit = 1'b1;
        fwd = sd[j];
      end
    end
  end

  assign lk_data = hit ? fwd : arr_rdata;

endmodule

// File: rtl/ddrsram_core.sv
// Storage array: one synchronous write port, one combinational read port.
module ddrsram_core #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ddrsram_rd_pipe.sv
// Fixed-latency read pipeline; data is zeroed on invalid beats.
module ddrsram_rd_pipe #(
  parameter int DW  = 36,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [DW-1:0] in_d,
  output logic          out_v,
  output logic [DW-1:0] out_d
);

  logic          v_s [LAT+1];
  logic [DW-1:0] d_s [LAT+1];

  assign v_s[0] = in_v;
  assign d_s[0] = in_v ? in_d : '0;

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    logic          v_q;
    logic [DW-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= v_s[i];
        d_q <= d_s[i];
      end
    end

    assign v_s[i+1] = v_q;
    assign d_s[i+1] = d_q;
  end

  assign out_v = v_s[LAT];
  assign out_d = d_s[LAT];

endmodule

// File: rtl/ddrsram_port.sv
module ddrsram_port #(
  parameter int AW     = 8,
  parameter int DW     = 36,
  parameter int BLB    = 2,
  parameter int RD_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          k_beat,
  output logic          ld_err
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_int = rs_q[1];

  logic           beat_act, beat_rd;
  logic [BLB-1:0] beat_idx;
  logic [AW-1:0]  beat_addr;
  logic           cm_we;
  logic [AW-1:0]  cm_addr;
  logic [DW-1:0]  cm_data, arr_rdata, lk_data;

  ddrsram_beat_ctl #(.AW(AW), .BLB(BLB)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_int),
    .ld_n      (ld_n),
    .rw        (rw),
    .addr      (addr),
    .k_beat    (k_beat),
    .beat_act  (beat_act),
    .beat_rd   (beat_rd),
    .beat_idx  (beat_idx),
    .beat_addr (beat_addr),
    .drop_err  (ld_err)
  );

  ddrsram_late_wr #(.AW(AW), .DW(DW), .BLB(BLB)) u_lw (
    .clk       (clk),
    .rst_n     (rst_int),
    .wr_beat   (beat_act & ~beat_rd),
    .beat_idx  (beat_idx),
    .beat_addr (beat_addr),
    .wdata     (wdata),
    .arr_rdata (arr_rdata),
    .lk_data   (lk_data),
    .cm_we     (cm_we),
    .cm_addr   (cm_addr),
    .cm_data   (cm_data)
  );

  ddrsram_core #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (cm_we),
    .waddr (cm_addr),
    .wdata (cm_data),
    .raddr (beat_addr),
    .rdata (arr_rdata)
  );

  ddrsram_rd_pipe #(.DW(DW), .LAT(RD_LAT)) u_rp (
    .clk   (clk),
    .rst_n (rst_int),
    .in_v  (beat_act & beat_rd),
    .in_d  (lk_data),
    .out_v (rvalid),
    .out_d (rdata)
  );

endmodule

// File: rtl/ddrsram_port_chk.sv
module ddrsram_port_chk #(
  parameter int DW  = 36,
  parameter int BLB = 2
) (
  input logic          clk,
  input logic          rst_i,
  input logic          ld_n,
  input logic          k_beat,
  input logic          rvalid,
  input logic [DW-1:0] rdata,
  input logic          ld_err
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      run_q <= '0;
    else if (rvalid) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  // R1
  k_alt_chk: assert property (@(posedge clk) disable iff (!rst_i)
    k_beat |=> !k_beat);

  // R1
  kbar_alt_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !k_beat |=> k_beat);

  // R6
  rd_run_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(rvalid) |-> (run_q != 8'd0 && run_q[BLB-1:0] == '0));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ld_err |-> $past(!ld_n && k_beat));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    ld_err |=> !ld_err);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !rvalid |-> rdata == '0);

endmodule

bind ddrsram_port ddrsram_port_chk #(.DW(DW), .BLB(BLB)) u_chk (
  .clk    (clk),
  .rst_i  (rst_int),
  .ld_n   (ld_n),
  .k_beat (k_beat),
  .rvalid (rvalid),
  .rdata  (rdata),
  .ld_err (ld_err)
);

// File: tb/sim_ddrsram_port.sv
`timescale 1ns/1ps
module sim_ddrsram_port;

  localparam int NB = 4096;

  logic        clk;
  logic        rst_n;
  logic        ld_n;
  logic        rw;
  logic [7:0]  addr;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic        rvalid;
  logic        k_beat;
  logic        ld_err;

  ddrsram_port u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .k_beat(k_beat),
    .ld_err(ld_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          checks = 0;
  int          failures = 0;
  int          bn = 0;
  bit          mon_on = 0;
  bit          done = 0;
  bit          exp_v [NB];
  bit          exp_e [NB];
  logic [35:0] exp_d [NB];
  string       exp_t [NB];
  logic [35:0] ref_m [256];

  always @(posedge clk) bn <= bn + 1;

  function automatic logic [35:0] rnd36();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return t[35:0];
  endfunction

  function automatic logic [7:0] bad(input logic [7:0] a, input int k);
    return {a[7:2], a[1:0] + 2'(k)};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output monitor: compares each beat against the expected schedule.
  always @(negedge clk) begin
    if (mon_on && bn < NB) begin
      if (rvalid || exp_v[bn])
        check(exp_v[bn] ? exp_t[bn] : "R2 rvalid", {35'd0, rvalid}, {35'd0, exp_v[bn]});
      if (rvalid && exp_v[bn])
        check(exp_t[bn], rdata, exp_d[bn]);
      if (!rvalid && rdata !== '0)
        check("R10 rdata idle", rdata, '0);
      if (ld_err || exp_e[bn])
        check("R8 ld_err", {35'd0, ld_err}, {35'd0, exp_e[bn]});
    end
  end

  task automatic burst(input bit rd, input logic [7:0] a, input string tag);
    logic [35:0] wd [4];
    int e;
    while (!k_beat) @(negedge clk);
    e = bn + 1;
    ld_n = 1'b0; rw = rd; addr = a;
    for (int k = 0; k < 4; k++) begin
      if (rd) begin
        exp_v[e+3+k] = 1'b1;
        exp_d[e+3+k] = ref_m[bad(a, k)];
        exp_t[e+3+k] = tag;
      end else begin
        wd[k] = rnd36();
        ref_m[bad(a, k)] = wd[k];
      end
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin ld_n = 1'b1; addr = 8'($urandom); end
      wdata = rd ? rnd36() : wd[k];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_n = 1'b1; rw = 1'($urandom); addr = 8'($urandom);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b1; ld_n = 1'b1; rw = 1'b0; addr = '0; wdata = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 rvalid", {35'd0, rvalid}, 36'd0);
    check("R11 ld_err", {35'd0, ld_err}, 36'd0);
    check("R11 rdata", rdata, '0);
    check("R11 k_beat", {35'd0, k_beat}, 36'd1);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;
  endtask

  task automatic t_fill();
    for (int g = 0; g < 8; g++) burst(1'b0, 8'(g * 4), "R5 write");
    for (int g = 0; g < 8; g++) burst(1'b1, 8'(g * 4), "R6 aligned read");
    idle(6);
    burst(1'b0, 8'd6, "R3 write wrap");
    burst(1'b0, 8'd13, "R3 write wrap");
    idle(6);
    burst(1'b1, 8'd4, "R3 read group");
    burst(1'b1, 8'd15, "R3 read wrap");
    burst(1'b1, 8'd9, "R4 read");
    idle(8);
  endtask

  task automatic t_pending();
    burst(1'b0, 8'd20, "R5 write");
    burst(1'b1, 8'd20, "R9 read after write");
    burst(1'b1, 8'd22, "R7 read pending wrap");
    burst(1'b0, 8'd24, "R5 write");
    burst(1'b1, 8'd21, "R7 read committed");
    burst(1'b1, 8'd25, "R7 read pending");
    idle(8);
  endtask

  task automatic t_rd2wr();
    burst(1'b1, 8'd0, "R6 read");
    burst(1'b0, 8'd0, "R9 write after read");
    burst(1'b1, 8'd2, "R9 read new data");
    idle(8);
  endtask

  task automatic t_kbar();
    while (!k_beat) @(negedge clk);
    @(negedge clk);
    ld_n = 1'b0; rw = 1'b0; addr = 8'd28; wdata = rnd36();
    @(negedge clk);
    ld_n = 1'b1;
    idle(8);
    burst(1'b1, 8'd28, "R1 K# load ignored");
    idle(8);
  endtask

  task automatic t_collide();
    int e;
    while (!k_beat) @(negedge clk);
    e = bn + 1;
    ld_n = 1'b0; rw = 1'b1; addr = 8'd17;
    for (int k = 0; k < 4; k++) begin
      exp_v[e+3+k] = 1'b1;
      exp_d[e+3+k] = ref_m[bad(8'd17, k)];
      exp_t[e+3+k] = "R8 burst undisturbed";
    end
    exp_e[e+2] = 1'b1;
    @(negedge clk); ld_n = 1'b1;
    @(negedge clk); ld_n = 1'b0; rw = 1'b0; addr = 8'd8; wdata = rnd36();
    @(negedge clk); ld_n = 1'b1; wdata = rnd36();
    @(negedge clk); wdata = rnd36();
    idle(8);
    burst(1'b1, 8'd8, "R8 dropped write");
    idle(8);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ld_n = 1'b1; rw = 1'b1; addr = 8'($urandom);
      check("R2 no op", {35'd0, rvalid}, 36'd0);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      burst(1'($urandom), 8'($urandom_range(0, 15)), "R7 random");
      if ($urandom_range(0, 3) == 0) idle(2);
    end
    idle(8);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_pending();
    t_rd2wr();
    t_kbar();
    t_collide();
    t_idle();
    t_random();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule